// File: doc/BRIEF.md
# Dual-Issue In-Order Dispatch Controller

This block sits between the bottom of an instruction queue and a set of execution units. Every cycle it looks at the two oldest queued instructions and decides which of them may leave for an execution unit in that cycle. Each queued entry carries an instruction class (which names the kind of unit it needs) and a bit mask of the rename-register classes its results will occupy. The controller combines that with a vacancy bit per unit, a free count per rename class and the free-slot count of the completion queue. It produces a grant per slot, the chosen unit for each grant, how many entries leave the queue, and how many rename registers and completion entries to allocate.

The queue itself is a small shift register inside the block, written from a push port. Grants are combinational from the queue contents and the resource inputs; the queue shifts down by the pop count at the next clock edge. The unit set is two integer units (the first also handles multiply and divide), one floating-point unit, one load/store unit and one system-register unit.

Top module: `disp_ctrl`

## Requirements
- R1: Only queue positions 0 and 1 are candidates; at each clock edge the queue drops the granted entries from its bottom, so the entry that was at position 2 moves to position 0 after a double grant and the count becomes count − pop + accepted push.
- R2: Dispatch is in order: slot 1 is never granted in a cycle where slot 0 is not granted.
- R3: At most two grants per cycle, and the two grants of a cycle never name the same unit.
- R4: A grant is given only toward a unit whose vacancy bit in `rs_free` is 1 (bit 0 first integer unit, 1 second integer unit, 2 floating point, 3 load/store, 4 system register).
- R5: Rename availability: each class in the destination mask (bit 0 integer register, 1 floating register, 2 condition register) needs one free register; when both slots are granted, the free count of a class must cover the sum of both requests, and `ren_alloc` reports that sum per class.
- R6: Each granted instruction takes one completion entry: with `cq_free` of 1 only slot 0 can be granted, with 0 nothing is granted, and `cq_alloc` equals `pop_cnt`.
- R7: Class codes: 0 simple integer, 1 multiply/divide, 2 floating point, 3 load/store, 4 system. Class 1 goes only to unit 0; class 0 goes to unit 1 when it is vacant and otherwise to unit 0.
- R8: After reset the queue is empty, no grant is given, and all allocation outputs are zero.
- R9: When the queue holds DEPTH entries, `push_ready` is 0 and a push has no effect on the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Write an entry into the queue |
| push_cls | input | 3 | Class of the pushed instruction |
| push_dst | input | 3 | Rename-class mask of the pushed instruction |
| push_ready | output | 1 | Queue has room |
| rs_free | input | 5 | Vacancy bit per execution unit |
| ren_free | input | 3×FREE_W | Free rename-register count per class |
| cq_free | input | CQ_W | Free completion-queue entries |
| disp_go | output | 2 | Grant per slot |
| disp_unit | output | 2×3 | Target unit per slot (0 when not granted) |
| pop_cnt | output | 2 | Entries leaving the queue this cycle |
| ren_alloc | output | 3×2 | Rename registers to allocate per class |
| cq_alloc | output | 2 | Completion entries to allocate |
| iq_cnt | output | $clog2(DEPTH+1) | Entries currently queued |

## Verification
The interesting overlap is unit steering and the second-slot resource check landing in one cycle: slot 0 holds a simple integer op whose preferred unit is busy, so it takes the first integer unit, while slot 1 holds a multiply that needs that same unit. The bench sets that pattern up through the push port and the vacancy bits and judges that only slot 0 is granted, toward unit 0, and that the multiply is then the sole remaining entry and is granted on the following cycle. A second overlap, the pop shift coinciding with a push into a full queue, is judged by draining the queue and counting the cycles until it is empty.

// File: rtl/disp_pkg.sv
package disp_pkg;

    localparam int NSLOT  = 2;
    localparam int NUNIT  = 5;
    localparam int UNIT_W = 3;
    localparam int NRC    = 3;
    localparam int CLS_W  = 3;

    typedef enum logic [CLS_W-1:0] {
        IC_INT    = 3'd0,
        IC_MULDIV = 3'd1,
        IC_FP     = 3'd2,
        IC_MEM    = 3'd3,
        IC_SYS    = 3'd4
    } iclass_e;

    localparam logic [UNIT_W-1:0] UNIT_IU1 = 3'd0;
    localparam logic [UNIT_W-1:0] UNIT_IU2 = 3'd1;
    localparam logic [UNIT_W-1:0] UNIT_FPU = 3'd2;
    localparam logic [UNIT_W-1:0] UNIT_LSU = 3'd3;
    localparam logic [UNIT_W-1:0] UNIT_SRU = 3'd4;

    typedef struct packed {
        iclass_e          cls;
        logic [NRC-1:0]   dst;
    } iq_entry_t;

    function automatic logic [NUNIT-1:0] unit_bit(input logic [UNIT_W-1:0] u);
        return NUNIT'(1) << u;
    endfunction

endpackage

// File: rtl/disp_iq.sv
module disp_iq
    import disp_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   push_valid,
    input  iq_entry_t              push_entry,
    output logic                   push_ready,
    input  logic [1:0]             pop_cnt,
    output iq_entry_t [NSLOT-1:0]  head,
    output logic [NSLOT-1:0]       head_valid,
    output logic [CNT_W-1:0]       count
);

    iq_entry_t q   [DEPTH];
    iq_entry_t q_n [DEPTH];
    logic [CNT_W-1:0] count_n;
    logic             push_ok;
    logic [CNT_W-1:0] wr_idx;

    assign push_ready = count < CNT_W'(DEPTH);
    assign push_ok    = push_valid & push_ready;
    assign wr_idx     = count - CNT_W'(pop_cnt);
    assign count_n    = count - CNT_W'(pop_cnt) + CNT_W'(push_ok);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            q_n[i] = '0;
            for (int k = 0; k < DEPTH; k++) begin
                if (k == i + int'(pop_cnt)) q_n[i] = q[k];
            end
            if (push_ok && (i == int'(wr_idx))) q_n[i] = push_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) q[i] <= '0;
        end else begin
            count <= count_n;
            for (int i = 0; i < DEPTH; i++) q[i] <= q_n[i];
        end
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_head
        assign head[s]       = q[s];
        assign head_valid[s] = count > CNT_W'(s);
    end

endmodule

// File: rtl/disp_route.sv
module disp_route
    import disp_pkg::*;
(
    input  iclass_e             cls,
    input  logic [NUNIT-1:0]    avail,
    output logic                found,
    output logic [UNIT_W-1:0]   unit
);

    always_comb begin
        found = 1'b0;
        unit  = '0;
        case (cls)
            IC_INT: begin
                if (avail[UNIT_IU2]) begin
                    found = 1'b1;
                    unit  = UNIT_IU2;
                end else if (avail[UNIT_IU1]) begin
                    found = 1'b1;
                    unit  = UNIT_IU1;
                end
            end
            IC_MULDIV: begin
                found = avail[UNIT_IU1];
                unit  = UNIT_IU1;
            end
            IC_FP: begin
                found = avail[UNIT_FPU];
                unit  = UNIT_FPU;
            end
            IC_MEM: begin
                found = avail[UNIT_LSU];
                unit  = UNIT_LSU;
            end
            IC_SYS: begin
                found = avail[UNIT_SRU];
                unit  = UNIT_SRU;
            end
            default: begin
                found = 1'b0;
                unit  = '0;
            end
        endcase
    end

endmodule

// File: rtl/disp_ctrl.sv
module disp_ctrl
    import disp_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int FREE_W = 4,
    parameter int CQ_W   = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           push_valid,
    input  logic [CLS_W-1:0]               push_cls,
    input  logic [NRC-1:0]                 push_dst,
    output logic                           push_ready,
    input  logic [NUNIT-1:0]               rs_free,
    input  logic [NRC-1:0][FREE_W-1:0]     ren_free,
    input  logic [CQ_W-1:0]                cq_free,
    output logic [NSLOT-1:0]               disp_go,
    output logic [NSLOT-1:0][UNIT_W-1:0]   disp_unit,
    output logic [1:0]                     pop_cnt,
    output logic [NRC-1:0][1:0]            ren_alloc,
    output logic [1:0]                     cq_alloc,
    output logic [CNT_W-1:0]               iq_cnt
);

    iq_entry_t              push_entry;
    iq_entry_t [NSLOT-1:0]  head;
    logic [NSLOT-1:0]       head_valid;

    logic [NUNIT-1:0]       mask [NSLOT+1];
    logic [1:0]             cum  [NSLOT+1][NRC];
    logic                   gate [NSLOT+1];
    logic [NSLOT-1:0]       fnd;
    logic [UNIT_W-1:0]      pick [NSLOT];
    logic [NSLOT-1:0]       go;

    assign push_entry.cls = iclass_e'(push_cls);
    assign push_entry.dst = push_dst;

    disp_iq #(.DEPTH(DEPTH)) u_iq (
        .clk        (clk),
        .rst        (rst),
        .push_valid (push_valid),
        .push_entry (push_entry),
        .push_ready (push_ready),
        .pop_cnt    (pop_cnt),
        .head       (head),
        .head_valid (head_valid),
        .count      (iq_cnt)
    );

    assign mask[0] = rs_free;
    assign gate[0] = 1'b1;
    for (genvar c = 0; c < NRC; c++) begin : g_cum0
        assign cum[0][c] = '0;
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic res_ok;
        logic cq_ok;

        disp_route u_rt (
            .cls   (head[s].cls),
            .avail (mask[s]),
            .found (fnd[s]),
            .unit  (pick[s])
        );

        assign mask[s+1] = fnd[s] ? (mask[s] & ~unit_bit(pick[s])) : mask[s];

        for (genvar c = 0; c < NRC; c++) begin : g_rc
            assign cum[s+1][c] = cum[s][c] + {1'b0, head[s].dst[c]};
        end

        always_comb begin
            res_ok = 1'b1;
            for (int c = 0; c < NRC; c++) begin
                if (ren_free[c] < FREE_W'(cum[s+1][c])) res_ok = 1'b0;
            end
        end

        assign cq_ok     = cq_free >= CQ_W'(s + 1);
        assign go[s]     = gate[s] & head_valid[s] & fnd[s] & res_ok & cq_ok;
        assign gate[s+1] = go[s];
        assign disp_unit[s] = go[s] ? pick[s] : '0;
    end

    assign disp_go = go;

    always_comb begin
        pop_cnt = '0;
        for (int s = 0; s < NSLOT; s++) pop_cnt = pop_cnt + 2'(go[s]);
    end

    always_comb begin
        for (int c = 0; c < NRC; c++) begin
            ren_alloc[c] = '0;
            for (int s = 0; s < NSLOT; s++) begin
                if (go[s]) ren_alloc[c] = cum[s+1][c];
            end
        end
    end

    assign cq_alloc = pop_cnt;

endmodule

// File: rtl/disp_chk.sv
module disp_chk
    import disp_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int FREE_W = 4,
    parameter int CQ_W   = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          push_valid,
    input logic                          push_ready,
    input logic [NUNIT-1:0]              rs_free,
    input logic [NRC-1:0][FREE_W-1:0]    ren_free,
    input logic [CQ_W-1:0]               cq_free,
    input logic [NSLOT-1:0]              disp_go,
    input logic [NSLOT-1:0][UNIT_W-1:0]  disp_unit,
    input logic [1:0]                    pop_cnt,
    input logic [NRC-1:0][1:0]           ren_alloc,
    input logic [1:0]                    cq_alloc,
    input logic [CNT_W-1:0]              iq_cnt,
    input iclass_e                       hd_cls0,
    input iclass_e                       hd_cls1
);

    // R2
    in_order_chk: assert property (@(posedge clk) disable iff (rst)
        disp_go[1] |-> disp_go[0]);

    // R3
    unit_distinct_chk: assert property (@(posedge clk) disable iff (rst)
        (disp_go[0] && disp_go[1]) |-> (disp_unit[0] != disp_unit[1]));

    // R4
    rs_vacant0_chk: assert property (@(posedge clk) disable iff (rst)
        disp_go[0] |-> rs_free[disp_unit[0]]);

    // R4
    rs_vacant1_chk: assert property (@(posedge clk) disable iff (rst)
        disp_go[1] |-> rs_free[disp_unit[1]]);

    // R7
    muldiv0_chk: assert property (@(posedge clk) disable iff (rst)
        (disp_go[0] && hd_cls0 == IC_MULDIV) |-> (disp_unit[0] == UNIT_IU1));

    // R7
    muldiv1_chk: assert property (@(posedge clk) disable iff (rst)
        (disp_go[1] && hd_cls1 == IC_MULDIV) |-> (disp_unit[1] == UNIT_IU1));

    // R6
    cq_room_chk: assert property (@(posedge clk) disable iff (rst)
        (CQ_W'(cq_alloc) <= cq_free) && (cq_alloc == pop_cnt));

    for (genvar c = 0; c < NRC; c++) begin : g_ren
        // R5
        ren_room_chk: assert property (@(posedge clk) disable iff (rst)
            FREE_W'(ren_alloc[c]) <= ren_free[c]);
    end

    // R1
    iq_track_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (iq_cnt == $past(iq_cnt - CNT_W'(pop_cnt) + CNT_W'(push_valid && push_ready))));

    // R9
    full_block_chk: assert property (@(posedge clk) disable iff (rst)
        (iq_cnt == CNT_W'(DEPTH)) |-> !push_ready);

endmodule

bind disp_ctrl disp_chk #(.DEPTH(DEPTH), .FREE_W(FREE_W), .CQ_W(CQ_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .rs_free    (rs_free),
    .ren_free   (ren_free),
    .cq_free    (cq_free),
    .disp_go    (disp_go),
    .disp_unit  (disp_unit),
    .pop_cnt    (pop_cnt),
    .ren_alloc  (ren_alloc),
    .cq_alloc   (cq_alloc),
    .iq_cnt     (iq_cnt),
    .hd_cls0    (head[0].cls),
    .hd_cls1    (head[1].cls)
);

// File: tb/sim_disp_ctrl.sv
module sim_disp_ctrl;

    localparam int CLK_P = 10;
    localparam int DEPTH = 6;

    logic             clk = 1'b0;
    logic             rst;
    logic             push_valid;
    logic [2:0]       push_cls;
    logic [2:0]       push_dst;
    logic             push_ready;
    logic [4:0]       rs_free;
    logic [2:0][3:0]  ren_free;
    logic [2:0]       cq_free;
    logic [1:0]       disp_go;
    logic [1:0][2:0]  disp_unit;
    logic [1:0]       pop_cnt;
    logic [2:0][1:0]  ren_alloc;
    logic [1:0]       cq_alloc;
    logic [2:0]       iq_cnt;

    int total = 0;
    int fails = 0;

    always #(CLK_P/2) clk = ~clk;

    disp_ctrl #(.DEPTH(DEPTH), .FREE_W(4), .CQ_W(3)) u0 (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_cls(push_cls),
        .push_dst(push_dst), .push_ready(push_ready), .rs_free(rs_free),
        .ren_free(ren_free), .cq_free(cq_free), .disp_go(disp_go),
        .disp_unit(disp_unit), .pop_cnt(pop_cnt), .ren_alloc(ren_alloc),
        .cq_alloc(cq_alloc), .iq_cnt(iq_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic close_all();
        rs_free  = '0;
        ren_free = '0;
        cq_free  = '0;
    endtask

    task automatic open_all();
        rs_free  = 5'b11111;
        ren_free = {4'd15, 4'd15, 4'd15};
        cq_free  = 3'd6;
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        push_valid = 1'b0;
        push_cls = '0;
        push_dst = '0;
        close_all();
        step();
        step();
        rst = 1'b0;
        #1;
    endtask

    task automatic push(input int c, input int d);
        push_valid = 1'b1;
        push_cls = 3'(c);
        push_dst = 3'(d);
        step();
        push_valid = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R8 iq_cnt", int'(iq_cnt), 0);
        chk("R8 disp_go", int'(disp_go), 0);
        chk("R8 ren_alloc", int'(ren_alloc), 0);
        chk("R8 cq_alloc", int'(cq_alloc), 0);
    endtask

    task automatic t_dual_int();
        do_reset();
        push(0, 1);
        push(0, 1);
        open_all();
        chk("R3 both granted", int'(disp_go), 3);
        chk("R7 slot0 unit", int'(disp_unit[0]), 1);
        chk("R3 slot1 unit", int'(disp_unit[1]), 0);
        chk("R5 gpr alloc", int'(ren_alloc[0]), 2);
        chk("R6 cq_alloc", int'(cq_alloc), 2);
        chk("R1 pop", int'(pop_cnt), 2);
        step();
        chk("R1 drained", int'(iq_cnt), 0);
    endtask

    task automatic t_muldiv_conflict();
        do_reset();
        push(0, 1);
        push(1, 1);
        open_all();
        rs_free = 5'b11101;
        #1;
        chk("R7 only slot0", int'(disp_go), 1);
        chk("R7 slot0 falls to unit0", int'(disp_unit[0]), 0);
        step();
        chk("R1 one left", int'(iq_cnt), 1);
        rs_free = 5'b11111;
        #1;
        chk("R7 muldiv granted", int'(disp_go), 1);
        chk("R7 muldiv unit", int'(disp_unit[0]), 0);
    endtask

    task automatic t_in_order();
        do_reset();
        push(2, 2);
        push(0, 1);
        open_all();
        rs_free = 5'b11011;
        #1;
        chk("R2 blocked head", int'(disp_go), 0);
        chk("R2 pop zero", int'(pop_cnt), 0);
    endtask

    task automatic t_rename();
        do_reset();
        push(0, 1);
        push(0, 1);
        open_all();
        ren_free[0] = 4'd1;
        #1;
        chk("R5 shared class", int'(disp_go), 1);
        chk("R5 gpr alloc one", int'(ren_alloc[0]), 1);
        ren_free[0] = 4'd0;
        #1;
        chk("R5 no gpr", int'(disp_go), 0);
        do_reset();
        push(2, 2);
        push(0, 1);
        open_all();
        ren_free = {4'd0, 4'd1, 4'd1};
        #1;
        chk("R5 distinct classes", int'(disp_go), 3);
        chk("R5 fpr alloc", int'(ren_alloc[1]), 1);
    endtask

    task automatic t_cq();
        do_reset();
        push(3, 1);
        push(4, 4);
        open_all();
        cq_free = 3'd1;
        #1;
        chk("R6 one entry", int'(disp_go), 1);
        chk("R6 cq_alloc one", int'(cq_alloc), 1);
        cq_free = 3'd0;
        #1;
        chk("R6 no entry", int'(disp_go), 0);
    endtask

    task automatic t_rs();
        do_reset();
        push(3, 1);
        open_all();
        rs_free = 5'b10111;
        #1;
        chk("R4 lsu busy", int'(disp_go), 0);
        rs_free = 5'b01000;
        #1;
        chk("R4 lsu vacant", int'(disp_go), 1);
        chk("R4 lsu unit", int'(disp_unit[0]), 3);
    endtask

    task automatic t_shift();
        do_reset();
        push(2, 2);
        push(3, 1);
        push(4, 4);
        open_all();
        chk("R1 pair units", int'(disp_unit[0]) * 8 + int'(disp_unit[1]), 2 * 8 + 3);
        step();
        chk("R1 third at head", int'(disp_go), 1);
        chk("R1 sys unit", int'(disp_unit[0]), 4);
        chk("R5 cr alloc", int'(ren_alloc[2]), 1);
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < DEPTH; i++) push(0, 1);
        chk("R9 full count", int'(iq_cnt), DEPTH);
        chk("R9 not ready", int'(push_ready), 0);
        push(1, 1);
        chk("R9 push ignored", int'(iq_cnt), DEPTH);
        open_all();
        for (int i = 0; i < DEPTH / 2; i++) step();
        chk("R9 drained empty", int'(iq_cnt), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_reset();
        t_dual_int();
        t_muldiv_conflict();
        t_in_order();
        t_rename();
        t_cq();
        t_rs();
        t_shift();
        t_full();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule